// File: doc/BRIEF.md
# Three-Wire Half-Duplex Serial Bus Master

This block runs register transactions to a clock/calendar peripheral over a three-wire link. The link has an active-high chip enable, a serial clock that idles low, and one shared data line that the master and the peripheral take turns driving. The host starts a transaction with a one-cycle start strobe. Along with the strobe it gives a 6-bit register address, a read/write flag, a byte count and a clock divider value.

Each transaction opens with a command byte that carries the address and the direction. A write then shifts out the host's data bytes. A read releases the data line after the last command bit and captures the peripheral's bytes. Every byte travels least significant bit first. Write bytes are pulled from the host one at a time with a take strobe. Read bytes are handed back one at a time with a valid strobe. A busy flag covers the whole transaction, and a done pulse follows once chip enable has dropped.

The data pin appears as three separate signals: an output value, an output enable and an input. A pad or the surrounding logic combines them into the tristate pin.

Top module: `tw_serial_master`

## Requirements
- R1: While idle (busy low), chip enable, serial clock and data output enable are all low.
- R2: The first byte of each transaction is the command byte. Bit 7 is 1, bits 6..1 hold the address, and bit 0 is 1 for a read and 0 for a write. It is sent bit 0 first.
- R3: Write data bytes go out least significant bit first, each sampled by the peripheral on a rising serial clock edge.
- R4: The outgoing data line changes only while the serial clock is low and holds steady for every high phase.
- R5: Each serial clock phase lasts div_i+1 system clock cycles. div_i is captured at the start strobe. The serial clock is low when chip enable rises and when it falls.
- R6: In a read, output enable stays high for all 8 command bits. It drops at the falling edge that ends the 8th command bit and stays low for the data bytes. Each read bit is sampled at the end of its low phase.
- R7: A transaction moves exactly len_i data bytes; len_i = 0 sends the command byte only. Each read byte is presented on rdata_o with a one-cycle rvalid_o pulse.
- R8: In a write, wtake_o pulses once per data byte, in the cycle where wdata_i is loaded. Byte n of the burst is the value on wdata_i at the nth take.
- R9: busy_o is high from the cycle after an accepted start until done_o. done_o is a single-cycle pulse issued with chip enable already low.
- R10: A start strobe while busy is ignored. No second command is sent.

FSM states: IDLE, CMD_LO, CMD_HI, DAT_LO, DAT_HI, HOLD, DONE.

Transitions:
- IDLE goes to CMD_LO on start.
- CMD_LO goes to CMD_HI when the phase timer expires.
- CMD_HI goes back to CMD_LO while command bits remain.
- After the 8th command bit, CMD_HI goes to DAT_LO, or to HOLD when the count is zero.
- DAT_LO goes to DAT_HI.
- DAT_HI goes back to DAT_LO while bits or bytes remain, otherwise to HOLD.
- HOLD goes to DONE.
- DONE goes to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| rd_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 6 | Register address |
| len_i | input | LEN_W | Number of data bytes |
| div_i | input | DIV_W | Serial clock phase length minus one, in system clocks |
| wdata_i | input | 8 | Write byte offered by the host |
| wtake_o | output | 1 | Pulse: wdata_i is consumed this cycle |
| rdata_o | output | 8 | Last captured read byte |
| rvalid_o | output | 1 | Pulse: rdata_o holds a new byte |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Pulse: transaction finished |
| ce_o | output | 1 | Chip enable, active high |
| sclk_o | output | 1 | Serial clock |
| sio_o | output | 1 | Data line output value |
| sio_oe_o | output | 1 | Data line output enable |
| sio_i | input | 1 | Data line input value |

## Verification
The bench models the peripheral. It decodes the command byte on rising edges and drives read bits after falling edges. This catches a design that sends bytes MSB first, misplaces the direction bit, or samples read data a phase late (shifted or rotated bytes).

Burst lengths of 0, 1, 8 and the maximum 15 expose off-by-one byte counting: an extra or missing rvalid or wtake.

Divider values of 0 and above check that the phase length tracks the latched divider. An output enable still asserted during read data is counted as contention. A start strobe issued mid-transaction shows whether a busy master wrongly restarts.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 6;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD_LO,
        ST_CMD_HI,
        ST_DAT_LO,
        ST_DAT_HI,
        ST_HOLD,
        ST_DONE
    } tw_state_e;

    // command byte: marker bit on top, address in the middle, direction in bit 0
    function automatic logic [BYTE_W-1:0] make_cmd(input logic [ADDR_W-1:0] a, input logic rd);
        return {1'b1, a, rd};
    endfunction
endpackage

// File: rtl/tw_half_timer.sv
module tw_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             reload,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick
);
    logic [DIV_W-1:0] per_q;
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q <= '0;
            cnt_q <= '0;
        end else if (arm) begin
            per_q <= div_i;
            cnt_q <= div_i;
        end else if (reload) begin
            cnt_q <= per_q;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - DIV_W'(1);
        end
    end

    assign tick = (cnt_q == '0);
endmodule

// File: rtl/tw_shift8.sv
module tw_shift8 #(
    parameter int W = tw_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift_out,
    input  logic         shift_in,
    input  logic         sin,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (shift_in)
            q <= {sin, q[W-1:1]};
        else if (shift_out)
            q <= {1'b0, q[W-1:1]};
    end
endmodule

// File: rtl/tw_serial_master.sv
module tw_serial_master
    import tw_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int LEN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic              wtake_o,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              ce_o,
    output logic              sclk_o,
    output logic              sio_o,
    output logic              sio_oe_o,
    input  logic              sio_i
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    tw_state_e            state_q, state_d;
    logic [BIT_CNT_W-1:0] bit_q;
    logic [LEN_W-1:0]     left_q;
    logic                 rd_q;
    logic [BYTE_W-1:0]    rdata_q;
    logic                 rvalid_q;

    logic                 tick;
    logic                 accept;
    logic                 last_bit;
    logic                 hi_phase;
    logic                 byte_end;
    logic                 sh_load, sh_out, sh_in;
    logic [BYTE_W-1:0]    sh_val, sh_q;

    assign accept   = (state_q == ST_IDLE) && start_i;
    assign last_bit = (bit_q == LAST_BIT);
    assign hi_phase = (state_q == ST_CMD_HI) || (state_q == ST_DAT_HI);
    assign byte_end = tick && last_bit && hi_phase;

    tw_half_timer #(.DIV_W(DIV_W)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (accept),
        .reload (tick && (state_q != ST_IDLE)),
        .div_i  (div_i),
        .tick   (tick)
    );

    // write byte is pulled when the next phase is a data low phase of a write
    assign wtake_o  = byte_end && !rd_q && (state_d == ST_DAT_LO);
    assign sh_load  = accept || wtake_o;
    assign sh_val   = accept ? make_cmd(addr_i, rd_i) : wdata_i;
    assign sh_out   = tick && !last_bit &&
                      ((state_q == ST_CMD_HI) || ((state_q == ST_DAT_HI) && !rd_q));
    assign sh_in    = tick && (state_q == ST_DAT_LO) && rd_q;

    tw_shift8 #(.W(BYTE_W)) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_val  (sh_val),
        .shift_out (sh_out),
        .shift_in  (sh_in),
        .sin       (sio_i),
        .q         (sh_q)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_CMD_LO;
            ST_CMD_LO: if (tick) state_d = ST_CMD_HI;
            ST_CMD_HI: if (tick) begin
                if (!last_bit)            state_d = ST_CMD_LO;
                else if (left_q == '0)    state_d = ST_HOLD;
                else                      state_d = ST_DAT_LO;
            end
            ST_DAT_LO: if (tick) state_d = ST_DAT_HI;
            ST_DAT_HI: if (tick) begin
                if (last_bit && (left_q == LEN_W'(1))) state_d = ST_HOLD;
                else                                   state_d = ST_DAT_LO;
            end
            ST_HOLD:   if (tick) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and transaction bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bit_q    <= '0;
            left_q   <= '0;
            rd_q     <= 1'b0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            rvalid_q <= byte_end && rd_q && (state_q == ST_DAT_HI);
            if (byte_end && rd_q && (state_q == ST_DAT_HI))
                rdata_q <= sh_q;
            if (accept) begin
                bit_q  <= '0;
                left_q <= len_i;
                rd_q   <= rd_i;
            end else if (tick && hi_phase) begin
                bit_q <= bit_q + BIT_CNT_W'(1);
                if (last_bit && (state_q == ST_DAT_HI))
                    left_q <= left_q - LEN_W'(1);
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        ce_o     = 1'b0;
        sclk_o   = 1'b0;
        sio_oe_o = 1'b0;
        busy_o   = (state_q != ST_IDLE);
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_CMD_LO: begin ce_o = 1'b1; sio_oe_o = 1'b1; end
            ST_CMD_HI: begin ce_o = 1'b1; sio_oe_o = 1'b1; sclk_o = 1'b1; end
            ST_DAT_LO: begin ce_o = 1'b1; sio_oe_o = !rd_q; end
            ST_DAT_HI: begin ce_o = 1'b1; sio_oe_o = !rd_q; sclk_o = 1'b1; end
            ST_HOLD:   ce_o = 1'b1;
            ST_DONE:   done_o = 1'b1;
            default:   ;
        endcase
        sio_o = sio_oe_o & sh_q[0];
    end

    assign rdata_o  = rdata_q;
    assign rvalid_o = rvalid_q;
endmodule

// File: rtl/tw_master_chk.sv
module tw_master_chk (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic done_o,
    input logic ce_o,
    input logic sclk_o,
    input logic sio_o,
    input logic sio_oe_o,
    input logic rvalid_o
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!ce_o && !sclk_o && !sio_oe_o));

    // R4
    sio_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sio_o));

    // R5
    ce_edge_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ce_o) || $fell(ce_o)) |-> (!sclk_o && !$past(sclk_o)));

    // R9
    done_after_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!ce_o && $past(ce_o)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    oe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sio_oe_o |-> ce_o);

    // R7
    rvalid_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> (ce_o && !sio_oe_o));
endmodule

bind tw_serial_master tw_master_chk chk_i (.*);

// File: tb/tw_serial_master_tb.sv
module tw_serial_master_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       rd_i = 1'b0;
    logic [5:0] addr_i = '0;
    logic [3:0] len_i = '0;
    logic [7:0] div_i = '0;
    logic [7:0] wdata_i;
    logic       wtake_o, rvalid_o, busy_o, done_o, ce_o, sclk_o, sio_o, sio_oe_o;
    logic [7:0] rdata_o;
    logic       sio_i = 1'b0;

    always #10 clk = ~clk;

    tw_serial_master #(.DIV_W(8), .LEN_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i), .addr_i(addr_i),
        .len_i(len_i), .div_i(div_i), .wdata_i(wdata_i), .wtake_o(wtake_o),
        .rdata_o(rdata_o), .rvalid_o(rvalid_o), .busy_o(busy_o), .done_o(done_o),
        .ce_o(ce_o), .sclk_o(sclk_o), .sio_o(sio_o), .sio_oe_o(sio_oe_o), .sio_i(sio_i)
    );

    function automatic logic [7:0] rbyte(input logic [5:0] a, input int k);
        return 8'(int'(a) * 7 + k * 53 + 150);
    endfunction
    function automatic logic [7:0] wpat(input logic [5:0] a, input int k);
        return 8'(k * 29 + int'(a) + 60);
    endfunction

    int checks = 0, fails = 0;
    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // write data source
    int widx = 0, wbase = 0;
    assign wdata_i = wpat(addr_i, widx - wbase);
    always @(posedge clk) if (wtake_o) widx <= widx + 1;

    // peripheral model and monitors, all sampled at the falling system clock
    logic [7:0] wcap [0:255];
    logic [7:0] rcap [0:255];
    logic [7:0] s_cmd = '0, s_wb = '0;
    int s_bits = 0, wn = 0, rn = 0, cmd_n = 0, done_n = 0;
    int hrun = 0, per_bad = 0, hold_bad = 0, oe_bad = 0, done_bad = 0;
    int cur_div = 0;
    logic p_ce = 0, p_sclk = 0, p_sio = 0;

    always @(negedge clk) begin
        if (ce_o && !p_ce) begin s_bits = 0; s_cmd = '0; cmd_n++; end
        if (ce_o && sclk_o && !p_sclk) begin
            if (s_bits < 8) begin
                s_cmd[s_bits] = sio_o;
                if (!sio_oe_o) oe_bad++;
            end else if (s_cmd[0]) begin
                if (sio_oe_o) oe_bad++;
            end else begin
                s_wb[(s_bits - 8) % 8] = sio_o;
                if ((s_bits - 8) % 8 == 7) begin wcap[wn[7:0]] = s_wb; wn++; end
            end
            s_bits++;
        end
        if (ce_o && !sclk_o && p_sclk && s_bits >= 8 && s_cmd[0]) begin
            automatic int k = s_bits - 8;
            automatic logic [7:0] b = rbyte(s_cmd[6:1], k / 8);
            sio_i = b[k % 8];
        end
        if (sclk_o) hrun++;
        else if (hrun != 0) begin
            if (hrun != cur_div + 1) per_bad++;
            hrun = 0;
        end
        if (sclk_o && p_sclk && sio_o != p_sio) hold_bad++;
        if (rvalid_o) begin rcap[rn[7:0]] = rdata_o; rn++; end
        if (done_o) begin done_n++; if (ce_o) done_bad++; end
        p_ce = ce_o; p_sclk = sclk_o; p_sio = sio_o;
    end

    int wb0, rb0, cb0, db0, pb0, hb0, ob0, xb0;
    task automatic snap();
        wb0 = wn; rb0 = rn; cb0 = cmd_n; db0 = done_n;
        pb0 = per_bad; hb0 = hold_bad; ob0 = oe_bad; xb0 = done_bad;
    endtask

    task automatic run_txn(input logic rd, input logic [5:0] a, input int len, input int dv);
        @(negedge clk);
        snap();
        wbase = widx; cur_div = dv;
        rd_i = rd; addr_i = a; len_i = 4'(len); div_i = 8'(dv); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (done_n == db0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic verify(input logic rd, input logic [5:0] a, input int len);
        int bad = 0, fa = 0, fe = 0;
        check(cmd_n - cb0 == 1 && s_cmd == {1'b1, a, rd}, "R2 command byte", s_cmd, {1'b1, a, rd});
        if (rd) begin
            check(rn - rb0 == len, "R7 read byte count", rn - rb0, len);
            for (int i = 0; i < len; i++)
                if (rcap[8'(rb0 + i)] != rbyte(a, i)) begin
                    if (bad == 0) begin fa = rcap[8'(rb0 + i)]; fe = rbyte(a, i); end
                    bad++;
                end
            check(bad == 0, "R6 read bytes LSB first", fa, fe);
            check(oe_bad == ob0, "R6 output enable turnaround", oe_bad - ob0, 0);
        end else begin
            check(wn - wb0 == len && rn == rb0, "R8 write byte count", wn - wb0, len);
            for (int i = 0; i < len; i++)
                if (wcap[8'(wb0 + i)] != wpat(a, i)) begin
                    if (bad == 0) begin fa = wcap[8'(wb0 + i)]; fe = wpat(a, i); end
                    bad++;
                end
            check(bad == 0, "R3 write bytes LSB first", fa, fe);
        end
        check(hold_bad == hb0, "R4 data steady while clock high", hold_bad - hb0, 0);
        check(per_bad == pb0, "R5 phase length", per_bad - pb0, 0);
        check(done_n - db0 == 1 && done_bad == xb0, "R9 single done with ce low", done_n - db0, 1);
    endtask

    // vectors: {rd, addr, len, div}
    localparam int NV = 7;
    localparam logic [18:0] VEC [0:NV-1] = '{
        {1'b0, 6'h00, 4'd1,  8'd1},
        {1'b1, 6'h00, 4'd1,  8'd2},
        {1'b0, 6'h1F, 4'd8,  8'd0},
        {1'b1, 6'h1F, 4'd8,  8'd1},
        {1'b1, 6'h2A, 4'd3,  8'd3},
        {1'b0, 6'h15, 4'd2,  8'd4},
        {1'b1, 6'h3F, 4'd15, 8'd0}
    };

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check(!ce_o && !sclk_o && !sio_oe_o && !busy_o && !done_o && !rvalid_o,
              "R1 reset idle outputs", {ce_o, sclk_o, sio_oe_o, busy_o, done_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_txn(VEC[v][18], VEC[v][17:12], int'(VEC[v][11:8]), int'(VEC[v][7:0]));
            verify(VEC[v][18], VEC[v][17:12], int'(VEC[v][11:8]));
            check(!ce_o && !busy_o && !sio_oe_o, "R1 idle after transaction",
                  {ce_o, busy_o, sio_oe_o}, 0);
        end

        // R7 zero-length read: command only
        run_txn(1'b1, 6'h07, 0, 2);
        check(s_bits == 8, "R7 zero length clocks only command", s_bits, 8);
        check(rn == rb0, "R7 zero length no read strobe", rn - rb0, 0);
        check(s_cmd == 8'h8F, "R2 zero length command", s_cmd, 8'h8F);

        // R10 start while busy is ignored, R9 busy follows start
        @(negedge clk);
        snap();
        wbase = widx; cur_div = 1;
        rd_i = 1'b0; addr_i = 6'h05; len_i = 4'd2; div_i = 8'd1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
        repeat (6) @(negedge clk);
        rd_i = 1'b1; addr_i = 6'h09; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; rd_i = 1'b0; addr_i = 6'h05;
        while (done_n == db0) @(negedge clk);
        repeat (10) @(negedge clk);
        check(cmd_n - cb0 == 1, "R10 no second command", cmd_n - cb0, 1);
        check(s_cmd == 8'h8A, "R10 original command kept", s_cmd, 8'h8A);
        check(!busy_o && !ce_o, "R10 stays idle", {busy_o, ce_o}, 0);
        verify(1'b0, 6'h05, 2);

        finish_up();
    end
endmodule